// File: doc/BRIEF.md
# Flash Unlock Command Sequencer

This block is the command front end of a flash device. It watches single-cycle write strobes, each with a 16-bit address and a 16-bit data word. It recognises the guarded multi-write instructions, and from them it sets the device mode: array read, identification-code read or operation status. When a program or chip-erase instruction completes correctly, it issues a one-cycle start pulse to the program/erase engine. For a program, the pulse comes with the target address and data, captured at the same time. While the engine runs, the sequencer follows the engine's busy and fail flags and shows status mode.

Every instruction begins with a two-write unlock pair. The command code follows it. A chip erase repeats the unlock pair and then writes a confirm code. Any write that does not fit the expected step drops the sequencer back to array read. Writes that arrive while the engine is busy are dropped. They do not move the sequencer.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the mode is array read (0), both start pulses are low and the captured program address and data are zero.
- R2: The unlock pair (data AAh at address 555h, then data 55h at address 2AAh) followed by data 90h at address 555h selects identification mode. Mode encoding: 0 = array read, 1 = identification, 2 = status.
- R3: Unlock and command addresses are compared on address bits 10:0 only, and unlock and command codes on data bits 7:0 only. Higher bits have no effect.
- R4: The unlock pair, then A0h at 555h, then any fourth write raises `prog_start` for exactly one cycle, in the cycle after that write. In the same cycle `prog_addr` and `prog_data` hold that write's address and data.
- R5: The unlock pair, 80h at 555h, the unlock pair again, then 10h at 555h raises `erase_start` for exactly one cycle, in the cycle after the sixth write.
- R6: During an erase instruction, a wrong second unlock pair or a wrong confirm code returns the mode to array read and issues no pulse.
- R7: An unknown command code, a command written to an address other than 555h, or an unlock step out of order returns the mode to array read.
- R8: A write of F0h selects array read. It works either as a single write or as the third write after the unlock pair.
- R9: From a start pulse onward the mode is status. The mode stays status until the engine has raised busy and then dropped it. If fail is high when busy drops, status holds until an F0h write.
- R10: Writes made while `eng_busy` is high are ignored, F0h included. They do not advance any sequence.
- R11: `sig_data` is 0020h for `sig_sel`=00 and 00C1h for `sig_sel`=01 in identification mode. It is zero for other selections and in every other mode.
- R12: Any write made in identification mode leaves that mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_addr | input | 16 | Write address |
| wr_data | input | 16 | Write data |
| eng_busy | input | 1 | Program/erase engine running |
| eng_fail | input | 1 | Engine reports failure |
| sig_sel | input | 2 | Address bits 1:0 of an identification read |
| mode | output | 2 | Current mode (0 array, 1 identification, 2 status) |
| prog_start | output | 1 | One-cycle program start |
| prog_addr | output | 16 | Captured program address |
| prog_data | output | 16 | Captured program data |
| erase_start | output | 1 | One-cycle chip-erase start |
| sig_data | output | 16 | Identification code |

## Verification
The bench builds the block with its default parameters: 16-bit address and data, 11 compared address bits and 8-bit codes. Because the bus is wider than the compared fields, the bench can set address bits 11 to 15 and data bits 8 to 15 during unlock and command writes and show that they are ignored. Because the bench drives the engine flags directly, it can hold busy across writes, end an operation with a failure, and then show that only F0h releases status mode.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    typedef enum logic [1:0] {
        MODE_ARRAY  = 2'd0,
        MODE_IDENT  = 2'd1,
        MODE_STATUS = 2'd2
    } fcs_mode_e;

    typedef enum logic [3:0] {
        ST_ARRAY  = 4'd0,
        ST_IDENT  = 4'd1,
        ST_UNL1   = 4'd2,
        ST_UNL2   = 4'd3,
        ST_PROG   = 4'd4,
        ST_ERS1   = 4'd5,
        ST_ERS2   = 4'd6,
        ST_ERS3   = 4'd7,
        ST_OPWAIT = 4'd8,
        ST_OPRUN  = 4'd9,
        ST_OPFAIL = 4'd10
    } fcs_state_e;

    typedef struct packed {
        logic unl_a;
        logic unl_b;
        logic cmd_addr;
        logic code_reset;
        logic code_ident;
        logic code_prog;
        logic code_erase;
        logic code_confirm;
    } fcs_cls_t;

endpackage

// File: rtl/fcs_match.sv
module fcs_match
    import fcs_pkg::*;
#(
    parameter int CMP_W = 11,
    parameter int CODE_W = 8,
    parameter logic [CMP_W-1:0]  ADDR_A = 11'h555,
    parameter logic [CMP_W-1:0]  ADDR_B = 11'h2AA,
    parameter logic [CODE_W-1:0] KEY_A = 8'hAA,
    parameter logic [CODE_W-1:0] KEY_B = 8'h55,
    parameter logic [CODE_W-1:0] C_RESET = 8'hF0,
    parameter logic [CODE_W-1:0] C_IDENT = 8'h90,
    parameter logic [CODE_W-1:0] C_PROG = 8'hA0,
    parameter logic [CODE_W-1:0] C_ERASE = 8'h80,
    parameter logic [CODE_W-1:0] C_CONFIRM = 8'h10
) (
    input  logic [CMP_W-1:0]  addr_i,
    input  logic [CODE_W-1:0] code_i,
    output fcs_cls_t          cls_o
);
    logic at_a;
    logic at_b;

    always_comb begin
        at_a = (addr_i == ADDR_A);
        at_b = (addr_i == ADDR_B);
        cls_o.unl_a        = at_a && (code_i == KEY_A);
        cls_o.unl_b        = at_b && (code_i == KEY_B);
        cls_o.cmd_addr     = at_a;
        cls_o.code_reset   = (code_i == C_RESET);
        cls_o.code_ident   = (code_i == C_IDENT);
        cls_o.code_prog    = (code_i == C_PROG);
        cls_o.code_erase   = (code_i == C_ERASE);
        cls_o.code_confirm = (code_i == C_CONFIRM);
    end
endmodule

// File: rtl/fcs_fsm.sv
module fcs_fsm
    import fcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  fcs_cls_t          cls_i,
    input  logic              eng_busy_i,
    input  logic              eng_fail_i,
    output fcs_mode_e         mode_o,
    output logic              prog_start_o,
    output logic [ADDR_W-1:0] prog_addr_o,
    output logic [DATA_W-1:0] prog_data_o,
    output logic              erase_start_o
);
    typedef struct packed {
        fcs_state_e        st;
        logic              prog_start;
        logic              erase_start;
        logic [ADDR_W-1:0] paddr;
        logic [DATA_W-1:0] pdata;
    } regs_t;

    regs_t r_q, r_d;
    logic  accept;

    always_comb begin
        accept = wr_stb_i && !eng_busy_i;
        r_d = r_q;
        r_d.prog_start  = 1'b0;
        r_d.erase_start = 1'b0;
        unique case (r_q.st)
            ST_OPWAIT: if (eng_busy_i) r_d.st = ST_OPRUN;
            ST_OPRUN:  if (!eng_busy_i) r_d.st = eng_fail_i ? ST_OPFAIL : ST_ARRAY;
            ST_OPFAIL: if (accept && cls_i.code_reset) r_d.st = ST_ARRAY;
            default: begin
                if (accept) begin
                    r_d.st = ST_ARRAY;
                    case (r_q.st)
                        ST_ARRAY, ST_IDENT: if (cls_i.unl_a) r_d.st = ST_UNL1;
                        ST_UNL1: if (cls_i.unl_b) r_d.st = ST_UNL2;
                        ST_UNL2: begin
                            if (cls_i.cmd_addr) begin
                                if (cls_i.code_ident)      r_d.st = ST_IDENT;
                                else if (cls_i.code_prog)  r_d.st = ST_PROG;
                                else if (cls_i.code_erase) r_d.st = ST_ERS1;
                            end
                        end
                        ST_PROG: begin
                            r_d.st         = ST_OPWAIT;
                            r_d.prog_start = 1'b1;
                            r_d.paddr      = wr_addr_i;
                            r_d.pdata      = wr_data_i;
                        end
                        ST_ERS1: if (cls_i.unl_a) r_d.st = ST_ERS2;
                        ST_ERS2: if (cls_i.unl_b) r_d.st = ST_ERS3;
                        ST_ERS3: begin
                            if (cls_i.cmd_addr && cls_i.code_confirm) begin
                                r_d.st          = ST_OPWAIT;
                                r_d.erase_start = 1'b1;
                            end
                        end
                        default: r_d.st = ST_ARRAY;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st          <= ST_ARRAY;
            r_q.prog_start  <= 1'b0;
            r_q.erase_start <= 1'b0;
            r_q.paddr       <= '0;
            r_q.pdata       <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (r_q.st)
            ST_IDENT:                       mode_o = MODE_IDENT;
            ST_OPWAIT, ST_OPRUN, ST_OPFAIL: mode_o = MODE_STATUS;
            default:                        mode_o = MODE_ARRAY;
        endcase
        prog_start_o  = r_q.prog_start;
        erase_start_o = r_q.erase_start;
        prog_addr_o   = r_q.paddr;
        prog_data_o   = r_q.pdata;
    end

    assert_one_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_start_o && erase_start_o));
    assert_prog_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start_o |=> !prog_start_o);
    assert_erase_after_confirm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_start_o) |-> $past(r_q.st) == ST_ERS3);
    assert_start_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_start_o || erase_start_o) |-> mode_o == MODE_STATUS);
    assert_busy_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy_i && r_q.st != ST_OPWAIT) |=> $stable(r_q.st));
endmodule

// File: rtl/fcs_ident.sv
module fcs_ident
    import fcs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter logic [DATA_W-1:0] MFR_CODE = 16'h0020,
    parameter logic [DATA_W-1:0] DEV_CODE = 16'h00C1
) (
    input  fcs_mode_e         mode_i,
    input  logic [1:0]        sel_i,
    output logic [DATA_W-1:0] data_o
);
    always_comb begin
        data_o = '0;
        if (mode_i == MODE_IDENT) begin
            case (sel_i)
                2'b00:   data_o = MFR_CODE;
                2'b01:   data_o = DEV_CODE;
                default: data_o = '0;
            endcase
        end
    end

    always_comb begin
        if (mode_i != MODE_IDENT) assert_ident_quiet_R11: assert (data_o == '0);
    end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int CMP_W = 11,
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              eng_busy,
    input  logic              eng_fail,
    input  logic [1:0]        sig_sel,
    output logic [1:0]        mode,
    output logic              prog_start,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              erase_start,
    output logic [DATA_W-1:0] sig_data
);
    fcs_cls_t  cls;
    fcs_mode_e mode_w;

    fcs_match #(.CMP_W(CMP_W), .CODE_W(CODE_W)) u_match (
        .addr_i (wr_addr[CMP_W-1:0]),
        .code_i (wr_data[CODE_W-1:0]),
        .cls_o  (cls)
    );

    fcs_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_stb_i      (wr_stb),
        .wr_addr_i     (wr_addr),
        .wr_data_i     (wr_data),
        .cls_i         (cls),
        .eng_busy_i    (eng_busy),
        .eng_fail_i    (eng_fail),
        .mode_o        (mode_w),
        .prog_start_o  (prog_start),
        .prog_addr_o   (prog_addr),
        .prog_data_o   (prog_data),
        .erase_start_o (erase_start)
    );

    fcs_ident #(.DATA_W(DATA_W)) u_ident (
        .mode_i (mode_w),
        .sel_i  (sig_sel),
        .data_o (sig_data)
    );

    assign mode = mode_w;
endmodule

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        eng_busy = 1'b0;
    logic        eng_fail = 1'b0;
    logic [1:0]  sig_sel = 2'b00;
    logic [1:0]  mode;
    logic        prog_start;
    logic [15:0] prog_addr;
    logic [15:0] prog_data;
    logic        erase_start;
    logic [15:0] sig_data;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    flash_cmd_seq u_flash_cmd_seq (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .eng_busy(eng_busy), .eng_fail(eng_fail),
        .sig_sel(sig_sel), .mode(mode), .prog_start(prog_start),
        .prog_addr(prog_addr), .prog_data(prog_data),
        .erase_start(erase_start), .sig_data(sig_data)
    );

    always #10 clk = ~clk;

    // behavioural reference: step counter, ident flag, operation phase
    int m_step = 0;
    int m_id = 0;
    int m_op = 0;
    int e_ps = 0;
    int e_es = 0;
    int e_pa = 0;
    int e_pd = 0;

    always @(posedge clk) begin
        int a;
        int d;
        if (!rst_n) begin
            m_step = 0; m_id = 0; m_op = 0; e_ps = 0; e_es = 0; e_pa = 0; e_pd = 0;
        end else begin
            e_ps = 0; e_es = 0;
            a = int'(wr_addr) % 2048;
            d = int'(wr_data) % 256;
            if (m_op == 1) begin
                if (eng_busy) m_op = 2;
            end else if (m_op == 2) begin
                if (!eng_busy) m_op = eng_fail ? 3 : 0;
            end else if (wr_stb && !eng_busy) begin
                if (m_op == 3) begin
                    if (d == 240) m_op = 0;
                end else begin
                    m_id = 0;
                    if (m_step == 0) m_step = (a == 1365 && d == 170) ? 1 : 0;
                    else if (m_step == 1) m_step = (a == 682 && d == 85) ? 2 : 0;
                    else if (m_step == 2) begin
                        m_step = 0;
                        if (a == 1365 && d == 144) m_id = 1;
                        else if (a == 1365 && d == 160) m_step = 3;
                        else if (a == 1365 && d == 128) m_step = 4;
                    end else if (m_step == 3) begin
                        m_step = 0; e_ps = 1; e_pa = int'(wr_addr); e_pd = int'(wr_data); m_op = 1;
                    end else if (m_step == 4) m_step = (a == 1365 && d == 170) ? 5 : 0;
                    else if (m_step == 5) m_step = (a == 682 && d == 85) ? 6 : 0;
                    else begin
                        m_step = 0;
                        if (a == 1365 && d == 16) begin e_es = 1; m_op = 1; end
                    end
                end
            end
        end
    end

    function automatic int exp_mode();
        return (m_op != 0) ? 2 : (m_id != 0 ? 1 : 0);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk("R2 mode", int'(mode), exp_mode());
            chk("R4 prog_start", int'(prog_start), e_ps);
            chk("R4 prog_addr", int'(prog_addr), e_pa);
            chk("R4 prog_data", int'(prog_data), e_pd);
            chk("R5 erase_start", int'(erase_start), e_es);
            chk("R11 sig_data", int'(sig_data),
                (m_id != 0) ? (sig_sel == 2'b00 ? 32 : (sig_sel == 2'b01 ? 193 : 0)) : 0);
        end
    end

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        wr_stb = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_stb = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic unlock();
        wr(16'h0555, 16'h00AA);
        wr(16'h02AA, 16'h0055);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_engine(input logic fail);
        eng_busy = 1'b1;
        idle(3);
        eng_fail = fail;
        eng_busy = 1'b0;
        idle(1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset mode", int'(mode), 0);
        chk("R1 reset prog_start", int'(prog_start), 0);
        chk("R1 reset erase_start", int'(erase_start), 0);
        chk("R1 reset prog_addr", int'(prog_addr), 0);
        idle(1);

        // R2 / R11: identification mode and codes
        unlock(); wr(16'h0555, 16'h0090);
        chk("R2 ident mode", int'(mode), 1);
        for (int s = 0; s < 4; s++) begin
            sig_sel = 2'(s); #1;
            chk("R11 ident code", int'(sig_data), s == 0 ? 16'h0020 : (s == 1 ? 16'h00C1 : 0));
            idle(1);
        end
        sig_sel = 2'b00;
        // R12: any write leaves ident mode
        wr(16'h1234, 16'h0000);
        chk("R12 leave ident", int'(mode), 0);
        #1; chk("R11 quiet outside ident", int'(sig_data), 0);

        // R3: high address and data bits are ignored
        wr(16'hF555, 16'h12AA); wr(16'h7AAA, 16'hFF55); wr(16'h0D55, 16'h3490);
        chk("R3 high bits ignored", int'(mode), 1);
        wr(16'h0155, 16'h00AA); wr(16'h02AA, 16'h0055); wr(16'h0555, 16'h0090);
        chk("R3 bit 10 compared", int'(mode), 0);

        // R4 / R9: program with clean finish
        unlock(); wr(16'h0555, 16'h00A0);
        wr(16'hBEEF, 16'h1234);
        chk("R4 prog pulse", int'(prog_start), 1);
        chk("R4 prog addr", int'(prog_addr), 16'hBEEF);
        chk("R4 prog data", int'(prog_data), 16'h1234);
        chk("R9 status", int'(mode), 2);
        idle(1);
        chk("R4 single pulse", int'(prog_start), 0);
        eng_busy = 1'b1; idle(1);
        // R10: reset ignored while busy
        wr(16'h0000, 16'h00F0);
        chk("R10 busy reset ignored", int'(mode), 2);
        eng_busy = 1'b0; idle(1);
        chk("R9 done to array", int'(mode), 0);

        // R9: failure holds status until F0
        unlock(); wr(16'h0555, 16'h00A0); wr(16'h0010, 16'h5A5A);
        run_engine(1'b1);
        eng_fail = 1'b0;
        chk("R9 fail hold", int'(mode), 2);
        wr(16'h0555, 16'h00AA);
        chk("R9 fail ignores unlock", int'(mode), 2);
        wr(16'h0000, 16'h00F0);
        chk("R9 F0 clears fail", int'(mode), 0);

        // R5: chip erase
        unlock(); wr(16'h0555, 16'h0080); unlock();
        wr(16'h0555, 16'h0010);
        chk("R5 erase pulse", int'(erase_start), 1);
        chk("R5 no prog pulse", int'(prog_start), 0);
        run_engine(1'b0);
        chk("R5 erase done", int'(mode), 0);

        // R6: wrong confirm and wrong second unlock
        unlock(); wr(16'h0555, 16'h0080); unlock();
        wr(16'h0555, 16'h0030);
        chk("R6 bad confirm", int'(erase_start), 0);
        chk("R6 bad confirm mode", int'(mode), 0);
        unlock(); wr(16'h0555, 16'h0080); wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0056);
        wr(16'h0555, 16'h0010);
        chk("R6 bad unlock", int'(erase_start), 0);
        chk("R6 bad unlock mode", int'(mode), 0);

        // R7: invalid code, wrong command address, out-of-order unlock
        unlock(); wr(16'h0555, 16'h0077); wr(16'h0000, 16'h1111);
        chk("R7 unknown code", int'(prog_start), 0);
        unlock(); wr(16'h0556, 16'h0090);
        chk("R7 wrong cmd addr", int'(mode), 0);
        wr(16'h02AA, 16'h0055); wr(16'h0555, 16'h00AA); wr(16'h0555, 16'h0090);
        chk("R7 out of order", int'(mode), 0);

        // R8: F0 single and after unlock
        unlock(); wr(16'h0555, 16'h0090);
        wr(16'h0123, 16'h00F0);
        chk("R8 single F0", int'(mode), 0);
        unlock(); wr(16'h0555, 16'h0090); unlock(); wr(16'h0555, 16'h00F0);
        chk("R8 F0 after unlock", int'(mode), 0);
        wr(16'h0555, 16'h00AA); wr(16'h0555, 16'h00F0);
        unlock(); wr(16'h0555, 16'h0090);
        chk("R8 F0 midway then ident", int'(mode), 1);
        wr(16'h0000, 16'h00F0);

        // R10: busy while idle freezes the sequence
        eng_busy = 1'b1;
        unlock(); wr(16'h0555, 16'h0090);
        eng_busy = 1'b0;
        wr(16'h0555, 16'h0090);
        chk("R10 busy writes dropped", int'(mode), 0);
        idle(2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule